// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a data cache controller placed between a processor port and a simple word-wide main-memory port. The processor presents a 32-bit byte address with a read or write request and holds it until the cache raises `reqReady`. The address is split into a tag, a set index and a byte offset. Both ways of the indexed set are compared in parallel, and the two comparisons are ORed into a hit. A read hit returns the selected 32-bit word in the same cycle. A write hit merges the enabled bytes into the line and marks it dirty, without touching memory.

On a miss the controller chooses a victim way. An empty way is used first. Otherwise the way named by the set's single least-recently-used bit is chosen. A dirty victim is first streamed out to memory as eight word beats. The missing 32-byte line is then fetched as eight read beats. Once the refill is complete the request is looked up again and completes as a hit. Write misses allocate the line in the same way.

Each beat on the memory port is a single request-and-accept exchange. `memValid` and `memAddr` are held until `memReady` is high. On a read beat, the memory returns `memRdata` for the addressed word in the accepting cycle.

Top module: `wb_cache_2way`

## Requirements
- R1: The byte address splits into a tag in bits [31:13], a set index in bits [12:5] and a line offset in bits [4:0]. The word within a line is bits [4:2], and bits [1:0] do not affect the word returned. Lines in different sets do not displace each other.
- R2: A read that hits raises `reqReady` in the cycle the request is presented, with the addressed word on `rspRdata`, and makes no memory beat.
- R3: A write that hits replaces byte k of the word (bits 8k+7:8k) exactly when `reqBe[k]` is 1, marks the line dirty, and makes no memory beat.
- R4: Reset clears every valid, dirty and LRU bit. The first access to any set after reset misses, and dirty data held before the reset is never written out.
- R5: A miss fetches the line as eight read beats at line base + 4k, with k rising from 0 to 7. The request then completes with data taken from the refilled line.
- R6: When the indexed set holds an invalid way, the refill goes there, with way 0 preferred over way 1. A valid line in the other way is kept.
- R7: Every hit and every completed refill points the set's LRU bit at the other way. When both ways are valid, the victim is the way the LRU bit names.
- R8: A dirty victim is written back as eight write beats at its own line base + 4k, with k ascending. All of these beats finish before the first refill read beat. A clean victim causes no write beat.
- R9: A write miss refills the line first and then merges the write into it. The line is left dirty, and memory keeps its old value.
- R10: `reqReady` stays low while the memory port is busy. `memAddr`, `memWrite` and `memWdata` stay stable while `memValid` is high and `memReady` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor request present, held until accepted |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the request |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte enables for a write |
| reqReady | output | 1 | Request completes this cycle |
| rspRdata | output | 32 | Read word, valid while reqReady is high |
| memValid | output | 1 | Memory beat requested |
| memWrite | output | 1 | 1 = write beat, 0 = read beat |
| memAddr | output | 32 | Word-aligned byte address of the beat |
| memWdata | output | 32 | Data of a write beat |
| memReady | input | 1 | Memory accepts the beat this cycle |
| memRdata | input | 32 | Data for a read beat, valid when accepted |

## Verification
On every cycle, the assertions check the memory-port ordering. A refill never starts before the dirty victim's last write beat. Write beats never resume once read beats have begun. Each burst starts at word 0 of a line, and refill reads target the requested line. They also check that beat signals hold under back-pressure and that the processor is never acknowledged while memory is busy. Only the bench's scenarios can show which way is chosen as victim, how the LRU bit follows an access history, and that byte-enable merges and write-back data are correct. They are also needed to show that reset discards dirty lines. The bench shows these by comparing returned words and memory contents with an independent model of the memory.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic hitUpd;   // a lookup hit completes this cycle
    logic hitWr;    // ... and it is a write
    logic fillBeat; // a refill read beat is accepted
    logic fillDone; // last refill beat: install tag and valid
    logic way;      // way under write-back or refill
  } wbcStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } wbcState_t;

endpackage

// File: rtl/wb_cache_dp.sv
module wb_cache_dp
  import wbc_pkg::*;
#(
  parameter  int ADDR_W     = 32,
  parameter  int SET_BITS   = 8,
  parameter  int OFF_BITS   = 5,
  parameter  int WORD_W     = 32,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int WOFF       = $clog2(WORD_BYTES),
  localparam int BEAT_W     = OFF_BITS - WOFF,
  localparam int TAG_W      = ADDR_W - SET_BITS - OFF_BITS,
  localparam int SETS       = 1 << SET_BITS,
  localparam int LINE_WORDS = 1 << BEAT_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  wbcStrb_t              strb,
  input  logic [BEAT_W-1:0]     beat,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [WORD_W-1:0]     reqWdata,
  input  logic [WORD_BYTES-1:0] reqBe,
  input  logic [WORD_W-1:0]     memRdata,
  output logic                  hit,
  output logic [WORD_W-1:0]     rdWord,
  output logic                  victimWay,
  output logic                  victimDirty,
  output logic [TAG_W-1:0]      selTag,
  output logic [WORD_W-1:0]     selWord
);

  logic [TAG_W-1:0]    reqTag;
  logic [SET_BITS-1:0] setIdx;
  logic [BEAT_W-1:0]   wordIdx;
  logic [WOFF-1:0]     unusedByteSel;

  assign reqTag        = reqAddr[ADDR_W-1 -: TAG_W];
  assign setIdx        = reqAddr[OFF_BITS +: SET_BITS];
  assign wordIdx       = reqAddr[WOFF +: BEAT_W];
  assign unusedByteSel = reqAddr[WOFF-1:0];

  logic [1:0]        wayHit;
  logic [1:0]        wayValid;
  logic [1:0]        wayDirty;
  logic [TAG_W-1:0]  wayTag      [2];
  logic [WORD_W-1:0] wayReqWord  [2];
  logic [WORD_W-1:0] wayBeatWord [2];
  logic [WORD_W-1:0] mergedWord;
  logic              hitWay;
  logic [SETS-1:0]   lruBits;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0]  tagMem  [SETS];
    logic [WORD_W-1:0] dataMem [SETS*LINE_WORDS];
    logic [SETS-1:0]   validBits;
    logic [SETS-1:0]   dirtyBits;
    logic              fillHere;
    logic              wrHere;

    assign fillHere       = (strb.way == 1'(w));
    assign wrHere         = strb.hitWr && (hitWay == 1'(w));
    assign wayValid[w]    = validBits[setIdx];
    assign wayDirty[w]    = dirtyBits[setIdx];
    assign wayTag[w]      = tagMem[setIdx];
    assign wayHit[w]      = validBits[setIdx] && (tagMem[setIdx] == reqTag);
    assign wayReqWord[w]  = dataMem[{setIdx, wordIdx}];
    assign wayBeatWord[w] = dataMem[{setIdx, beat}];

    always_ff @(posedge clk) begin
      if (strb.fillBeat && fillHere) begin
        dataMem[{setIdx, beat}] <= memRdata;
      end else if (wrHere) begin
        dataMem[{setIdx, wordIdx}] <= mergedWord;
      end
      if (strb.fillDone && fillHere) begin
        tagMem[setIdx] <= reqTag;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validBits <= '0;
        dirtyBits <= '0;
      end else if (strb.fillDone && fillHere) begin
        validBits[setIdx] <= 1'b1;
        dirtyBits[setIdx] <= 1'b0;
      end else if (wrHere) begin
        dirtyBits[setIdx] <= 1'b1;
      end
    end
  end

  assign hitWay = wayHit[1];
  assign hit    = |wayHit;
  assign rdWord = wayReqWord[hitWay];

  always_comb begin
    mergedWord = rdWord;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (reqBe[b]) mergedWord[b*8 +: 8] = reqWdata[b*8 +: 8];
    end
  end

  // Empty way first (way 0 preferred), otherwise the way the LRU bit names
  always_comb begin
    if (!wayValid[0])      victimWay = 1'b0;
    else if (!wayValid[1]) victimWay = 1'b1;
    else                   victimWay = lruBits[setIdx];
  end
  assign victimDirty = wayDirty[victimWay];

  assign selTag  = wayTag[strb.way];
  assign selWord = wayBeatWord[strb.way];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lruBits <= '0;
    end else if (strb.fillDone) begin
      lruBits[setIdx] <= ~strb.way;
    end else if (strb.hitUpd) begin
      lruBits[setIdx] <= ~hitWay;
    end
  end

endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import wbc_pkg::*;
#(
  parameter  int TAG_W    = 19,
  parameter  int SET_BITS = 8,
  parameter  int BEAT_W   = 3,
  parameter  int WOFF     = 2,
  localparam int ADDR_W   = TAG_W + SET_BITS + BEAT_W + WOFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [TAG_W-1:0]    reqTag,
  input  logic [SET_BITS-1:0] reqSet,
  input  logic                hit,
  input  logic                victimWay,
  input  logic                victimDirty,
  input  logic [TAG_W-1:0]    selTag,
  input  logic                memReady,
  output logic                reqReady,
  output wbcStrb_t            strb,
  output logic [BEAT_W-1:0]   beat,
  output logic                memValid,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memAddr
);

  wbcState_t         state;
  logic              wayQ;
  logic [BEAT_W-1:0] beatQ;
  logic              beatDone;
  logic              lastBeat;

  assign beat     = beatQ;
  assign memValid = (state != ST_IDLE);
  assign memWrite = (state == ST_WBACK);
  assign beatDone = memValid && memReady;
  assign lastBeat = (beatQ == '1);
  assign reqReady = (state == ST_IDLE) && reqValid && hit;
  assign memAddr  = {(state == ST_WBACK) ? selTag : reqTag, reqSet, beatQ, {WOFF{1'b0}}};

  always_comb begin
    strb          = '0;
    strb.way      = wayQ;
    strb.hitUpd   = reqReady;
    strb.hitWr    = reqReady && reqWrite;
    strb.fillBeat = (state == ST_FILL) && beatDone;
    strb.fillDone = (state == ST_FILL) && beatDone && lastBeat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wayQ  <= 1'b0;
      beatQ <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid && !hit) begin
            wayQ  <= victimWay;
            beatQ <= '0;
            state <= victimDirty ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: begin
          if (beatDone) begin
            beatQ <= beatQ + 1'b1;
            if (lastBeat) state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (beatDone) begin
            beatQ <= beatQ + 1'b1;
            if (lastBeat) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wb_cache_2way.sv
module wb_cache_2way
  import wbc_pkg::*;
#(
  parameter  int ADDR_W     = 32,
  parameter  int SET_BITS   = 8,
  parameter  int OFF_BITS   = 5,
  parameter  int WORD_W     = 32,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int WOFF       = $clog2(WORD_BYTES),
  localparam int BEAT_W     = OFF_BITS - WOFF,
  localparam int TAG_W      = ADDR_W - SET_BITS - OFF_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [WORD_W-1:0]     reqWdata,
  input  logic [WORD_BYTES-1:0] reqBe,
  output logic                  reqReady,
  output logic [WORD_W-1:0]     rspRdata,
  output logic                  memValid,
  output logic                  memWrite,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [WORD_W-1:0]     memWdata,
  input  logic                  memReady,
  input  logic [WORD_W-1:0]     memRdata
);

  wbcStrb_t          strb;
  logic [BEAT_W-1:0] beat;
  logic              hit;
  logic              victimWay;
  logic              victimDirty;
  logic [TAG_W-1:0]  selTag;

  wb_cache_dp #(
    .ADDR_W(ADDR_W), .SET_BITS(SET_BITS), .OFF_BITS(OFF_BITS), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .beat(beat),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .memRdata(memRdata),
    .hit(hit), .rdWord(rspRdata), .victimWay(victimWay), .victimDirty(victimDirty),
    .selTag(selTag), .selWord(memWdata)
  );

  wb_cache_ctrl #(
    .TAG_W(TAG_W), .SET_BITS(SET_BITS), .BEAT_W(BEAT_W), .WOFF(WOFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqTag(reqAddr[ADDR_W-1 -: TAG_W]), .reqSet(reqAddr[OFF_BITS +: SET_BITS]),
    .hit(hit), .victimWay(victimWay), .victimDirty(victimDirty), .selTag(selTag),
    .memReady(memReady), .reqReady(reqReady), .strb(strb), .beat(beat),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr)
  );

endmodule

// File: rtl/wb_cache_2way_chk.sv
module wb_cache_2way_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFF_BITS = 5,
  parameter int WORD_W   = 32,
  parameter int WOFF     = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              memValid,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic [WORD_W-1:0] memWdata,
  input logic              memReady
);

  logic [OFF_BITS-1:0] unusedReqOff;
  logic [WOFF-1:0]     unusedMemLsb;
  logic                lastWbBeat;

  assign unusedReqOff = reqAddr[OFF_BITS-1:0];
  assign unusedMemLsb = memAddr[WOFF-1:0];
  assign lastWbBeat   = memValid && memWrite && memReady && (memAddr[OFF_BITS-1:WOFF] == '1);

  // R2
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> reqValid);

  // R10
  no_ack_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !reqReady);

  // R10
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));

  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite && !memReady) |=> $stable(memWdata));

  // R8
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastWbBeat |=> (memValid && !memWrite));

  // R8
  no_write_after_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite) |=> !(memValid && memWrite));

  // R5
  burst_starts_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memValid) |-> (memAddr[OFF_BITS-1:WOFF] == '0));

  // R5
  fill_line_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memWrite) |-> (memAddr[ADDR_W-1:OFF_BITS] == reqAddr[ADDR_W-1:OFF_BITS]));

endmodule

bind wb_cache_2way wb_cache_2way_chk #(
  .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .WORD_W(WORD_W), .WOFF(WOFF)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
  .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
  .memReady(memReady)
);

// File: tb/tb_wb_cache_2way.sv
`timescale 1ns/1ps
module tb_wb_cache_2way;

  logic        clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rstN;
  logic        reqValid, reqWrite;
  logic [31:0] reqAddr, reqWdata;
  logic [3:0]  reqBe;
  logic        reqReady;
  logic [31:0] rspRdata;
  logic        memValid, memWrite;
  logic [31:0] memAddr, memWdata;
  logic        memReady;
  logic [31:0] memRdata;

  wb_cache_2way dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .reqReady(reqReady), .rspRdata(rspRdata),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata)
  );

  int testsRun = 0;
  int testsFailed = 0;

  // Memory model: an unwritten word holds its own byte address
  logic [31:0] memModel [logic [31:0]];
  function automatic logic [31:0] modelRead(input logic [31:0] a);
    if (memModel.exists(a)) return memModel[a];
    return a;
  endfunction

  int          cyc = 0;
  int          readBeats, writeBeats, orderErr;
  logic [31:0] wbAddrSeen;

  initial begin
    memReady = 1'b0;
    memRdata = '0;
  end

  always @(negedge clk) begin
    cyc++;
    memReady <= ((cyc % 3) != 1);
    memRdata <= modelRead(memAddr);
  end

  always @(posedge clk) begin
    if (rstN && memValid && memReady) begin
      if (memWrite) begin
        if (readBeats != 0) orderErr++;
        if (writeBeats == 0) wbAddrSeen = memAddr;
        else if (memAddr != wbAddrSeen + 32'(writeBeats * 4)) orderErr++;
        memModel[memAddr] = memWdata;
        writeBeats++;
      end else begin
        if (memAddr != {reqAddr[31:5], 5'b0} + 32'(readBeats * 4)) orderErr++;
        readBeats++;
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wdata,
                        input logic [3:0] be, output logic [31:0] rdata, output int waitCycles);
    @(negedge clk);
    readBeats = 0; writeBeats = 0; orderErr = 0; wbAddrSeen = '0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wdata; reqBe = be;
    waitCycles = 0; rdata = '0;
    forever begin
      #1;
      if (reqReady) begin
        rdata = rspRdata;
        break;
      end
      @(negedge clk);
      waitCycles++;
      if (waitCycles > 400) begin
        testsRun++; testsFailed++;
        $display("FAIL R10 request never completed act=%0d exp<=400", waitCycles);
        break;
      end
    end
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  be;
    logic [31:0] expData;
    logic [3:0]  expReads;
    logic [3:0]  expWrites;
    logic [31:0] wbBase;
    logic [3:0]  focus;   // requirement number the row targets
  } vec_t;

  localparam int NUM_VEC = 14;
  // Set 1 holds A=0x24 (tag 0), B=0x2024 (tag 1), C=0x4028 (tag 2)
  localparam vec_t VECS [NUM_VEC] = '{
    '{1'b0, 32'h0000_0024, 32'h0,         4'h0, 32'h0000_0024, 4'd8, 4'd0, 32'h0,    4'd4}, // R4 R5 cold miss, way0
    '{1'b0, 32'h0000_0024, 32'h0,         4'h0, 32'h0000_0024, 4'd0, 4'd0, 32'h0,    4'd2}, // R2 hit
    '{1'b1, 32'h0000_2024, 32'hDEADBEEF,  4'hF, 32'h0,         4'd8, 4'd0, 32'h0,    4'd9}, // R9 R6 write miss into way1
    '{1'b0, 32'h0000_2024, 32'h0,         4'h0, 32'hDEADBEEF,  4'd0, 4'd0, 32'h0,    4'd9}, // R9 merged write visible
    '{1'b1, 32'h0000_0024, 32'h12345678,  4'h3, 32'h0,         4'd0, 4'd0, 32'h0,    4'd3}, // R3 partial write hit
    '{1'b0, 32'h0000_0024, 32'h0,         4'h0, 32'h0000_5678, 4'd0, 4'd0, 32'h0,    4'd6}, // R3 R6 way0 kept
    '{1'b0, 32'h0000_4028, 32'h0,         4'h0, 32'h0000_4028, 4'd8, 4'd8, 32'h2020, 4'd7}, // R7 R8 evict dirty B
    '{1'b0, 32'h0000_2024, 32'h0,         4'h0, 32'hDEADBEEF,  4'd8, 4'd8, 32'h0020, 4'd8}, // R8 evict dirty A
    '{1'b0, 32'h0000_0024, 32'h0,         4'h0, 32'h0000_5678, 4'd8, 4'd0, 32'h0,    4'd8}, // R8 clean C dropped
    '{1'b0, 32'h0000_4028, 32'h0,         4'h0, 32'h0000_4028, 4'd8, 4'd0, 32'h0,    4'd7}, // R7 clean B dropped
    '{1'b0, 32'h0000_0040, 32'h0,         4'h0, 32'h0000_0040, 4'd8, 4'd0, 32'h0,    4'd1}, // R1 other set
    '{1'b0, 32'h0000_005C, 32'h0,         4'h0, 32'h0000_005C, 4'd0, 4'd0, 32'h0,    4'd1}, // R1 word 7 hit
    '{1'b1, 32'h0000_005C, 32'hAB000000,  4'h8, 32'h0,         4'd0, 4'd0, 32'h0,    4'd3}, // R3 top byte
    '{1'b0, 32'h0000_005C, 32'h0,         4'h0, 32'hAB00_005C, 4'd0, 4'd0, 32'h0,    4'd3}  // R3 merge result
  };

  initial begin
    logic [31:0] rd;
    int          waits;
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0; reqBe = '0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check("R4", "reset reqReady", 32'(reqReady), 32'd0);
    check("R4", "reset memValid", 32'(memValid), 32'd0);

    for (int i = 0; i < NUM_VEC; i++) begin
      vec_t v;
      v = VECS[i];
      access(v.wr, v.addr, v.wdata, v.be, rd, waits);
      if (!v.wr) check($sformatf("R%0d", v.focus), $sformatf("row %0d data", i), rd, v.expData);
      check("R5", $sformatf("row %0d read beats", i), 32'(readBeats), 32'(v.expReads));
      check("R8", $sformatf("row %0d write beats", i), 32'(writeBeats), 32'(v.expWrites));
      if (v.expWrites != 0)
        check("R8", $sformatf("row %0d write-back base", i), wbAddrSeen, v.wbBase);
      check("R8", $sformatf("row %0d beat order", i), 32'(orderErr), 32'd0);
      if (v.expReads != 0)
        check("R10", $sformatf("row %0d stall long enough", i),
              32'(waits >= int'(v.expReads) + int'(v.expWrites)), 32'd1);
    end

    // R1: byte-select bits do not change the word returned
    access(1'b0, 32'h0000_005F, '0, 4'h0, rd, waits);
    check("R1", "offset bits [1:0] ignored", rd, 32'hAB00_005C);
    check("R1", "no beats on hit", 32'(readBeats + writeBeats), 32'd0);

    // R9: write miss allocates, merges, leaves memory untouched
    access(1'b1, 32'h0000_0060, 32'h0000_00EE, 4'h1, rd, waits);
    check("R9", "write miss fetches line", 32'(readBeats), 32'd8);
    access(1'b0, 32'h0000_0060, '0, 4'h0, rd, waits);
    check("R9", "merged word after allocate", rd, 32'h0000_00EE);
    check("R9", "memory not yet written", modelRead(32'h0000_0060), 32'h0000_0060);

    // R4: reset drops dirty 0x5C line without writing it
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    access(1'b0, 32'h0000_005C, '0, 4'h0, rd, waits);
    check("R4", "miss after reset", 32'(readBeats), 32'd8);
    check("R4", "no write-back after reset", 32'(writeBeats), 32'd0);
    check("R4", "dirty data discarded", rd, 32'h0000_005C);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired act=%0d exp<200000", cyc);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule